// File: doc/BRIEF.md
# Banked Memory Window Registers

This block is the register and decode front end of a banked RAM expansion on an 8-bit host bus. The host sees a 256-byte window in one I/O area. Two write-only registers in a second I/O area choose which 256-byte page of a much larger external memory the window shows. One register picks a 16KB block and the other picks a page inside that block. The block joins the two register values with the host's low address byte to form the full expanded-memory address, and it raises a window-select flag while the host addresses the window.

Only A0 and A7 are decoded inside the register area. As a result the register pair repeats across the upper half of the area, and writes to the lower half go nowhere. In the standard build the block register is 5 bits wide and the page register is 6 bits wide, which addresses 512KB. A build parameter widens the block register to 8 bits, which addresses 4MB. Writes are synchronous to the block clock and take effect on the edge that samples a decoded write. Register values cannot be read back.

Top module: `mbw_window`

## Requirements
- R1: After reset both registers hold zero, so mem_addr equals the zero-extended addr input.
- R2: A clocked write with reg_area=1, wr_en=1, addr[7]=1 and addr[0]=1 loads the block register from wdata. The new value shows in mem_addr from the cycle after that edge.
- R3: A clocked write with reg_area=1, wr_en=1, addr[7]=1 and addr[0]=0 loads the page register from wdata, with the same one-cycle timing as R2.
- R4: addr[6:1] has no effect on register selection, so every offset 0x80..0xFF reaches the pair. Exactly one register at most is written per cycle.
- R5: A write with reg_area=1 and addr[7]=0 changes neither register.
- R6: No register changes in a cycle where reg_area=0 or wr_en=0. This includes writes that target the window area.
- R7: Only the low BLOCK_BITS bits of wdata (default 5) go into the block register, and only the low 6 bits go into the page register. The upper data bits are dropped.
- R8: mem_addr is {block, page, addr[7:0]}, so in the default build mem_addr = block*16384 + page*256 + addr. It follows addr in the same cycle with no register delay.
- R9: win_cs equals win_sel in the same cycle. Neither strobe alters mem_addr.
- R10: With BLOCK_BITS=8 the block register keeps all 8 data bits and mem_addr is 22 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; register writes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_area | input | 1 | Host strobe for the register area |
| win_sel | input | 1 | Host strobe for the 256-byte window area |
| wr_en | input | 1 | Host write strobe |
| addr | input | 8 | Host address bits 7..0 |
| wdata | input | 8 | Host write data |
| mem_addr | output | BLOCK_BITS+14 | Expanded-memory address {block, page, addr} |
| win_cs | output | 1 | Window access flag |

## Verification
The hardest case to reach is a mirror write. Here a register write lands at an offset inside the upper half that is neither of the two nominal top addresses. It is mixed with near-miss writes that differ from a hit only in A7, or only in the absence of the register strobe. The stimulus draws addr uniformly and sets or clears A7 on purpose. It also sends writes while only the window strobe is active, and it drives a default build and a wide build in parallel from the same bus. That way the masking of upper data bits and the 8-bit block path are checked on the same data byte.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFFS_W = 8;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_PAGE  = 2'd1,
    TGT_BLOCK = 2'd2
  } reg_tgt_e;

  // Partial decode: only the area strobe, the write strobe, A7 and A0 matter.
  function automatic reg_tgt_e decode_target(input logic area, input logic wr,
                                             input logic a7, input logic a0);
    reg_tgt_e t;
    t = TGT_NONE;
    if (area && wr && a7) begin
      t = a0 ? TGT_BLOCK : TGT_PAGE;
    end
    return t;
  endfunction

endpackage

// File: rtl/mbw_decode.sv
module mbw_decode
  import mbw_pkg::*;
(
  input  logic             reg_area,
  input  logic             wr_en,
  input  logic [OFFS_W-1:0] addr,
  output logic             wr_blk,
  output logic             wr_pg
);

  reg_tgt_e tgt;

  always_comb begin
    tgt    = decode_target(reg_area, wr_en, addr[OFFS_W-1], addr[0]);
    wr_blk = (tgt == TGT_BLOCK);
    wr_pg  = (tgt == TGT_PAGE);
  end

endmodule

// File: rtl/mbw_reg.sv
module mbw_reg #(
  parameter int unsigned W      = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [W-1:0]      q
);

  logic [W-1:0] d_kept;

  generate
    if (W >= DATA_W) begin : g_full
      always_comb begin
        d_kept = '0;
        d_kept[DATA_W-1:0] = d;
      end
    end else begin : g_slice
      assign d_kept = d[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= d_kept;
    end
  end

endmodule

// File: rtl/mbw_addr_form.sv
module mbw_addr_form #(
  parameter int unsigned BLK_W  = 5,
  parameter int unsigned PG_W   = 6,
  parameter int unsigned OFFS_W = 8,
  localparam int unsigned AW    = BLK_W + PG_W + OFFS_W
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic [PG_W-1:0]   pg,
  input  logic [OFFS_W-1:0] offs,
  output logic [AW-1:0]     xaddr
);

  assign xaddr = {blk, pg, offs};

endmodule

// File: rtl/mbw_window.sv
module mbw_window
  import mbw_pkg::*;
#(
  parameter int unsigned BLOCK_BITS = 5,
  parameter int unsigned PAGE_BITS  = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_area,
  input  logic                                  win_sel,
  input  logic                                  wr_en,
  input  logic [7:0]                            addr,
  input  logic [7:0]                            wdata,
  output logic [BLOCK_BITS+PAGE_BITS+7:0]       mem_addr,
  output logic                                  win_cs
);

  logic                  wr_blk;
  logic                  wr_pg;
  logic [BLOCK_BITS-1:0] blk_q;
  logic [PAGE_BITS-1:0]  pg_q;

  mbw_decode u_dec (
    .reg_area (reg_area),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_blk   (wr_blk),
    .wr_pg    (wr_pg)
  );

  mbw_reg #(.W(BLOCK_BITS), .DATA_W(DATA_W)) u_blk (
    .clk (clk), .rst_n (rst_n), .we (wr_blk), .d (wdata), .q (blk_q)
  );

  mbw_reg #(.W(PAGE_BITS), .DATA_W(DATA_W)) u_pg (
    .clk (clk), .rst_n (rst_n), .we (wr_pg), .d (wdata), .q (pg_q)
  );

  mbw_addr_form #(.BLK_W(BLOCK_BITS), .PG_W(PAGE_BITS), .OFFS_W(OFFS_W)) u_form (
    .blk   (blk_q),
    .pg    (pg_q),
    .offs  (addr),
    .xaddr (mem_addr)
  );

  assign win_cs = win_sel;

endmodule

// File: rtl/mbw_window_chk.sv
module mbw_window_chk #(
  parameter int unsigned BLOCK_BITS = 5,
  parameter int unsigned PAGE_BITS  = 6
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            reg_area,
  input logic                            wr_en,
  input logic [7:0]                      addr,
  input logic [7:0]                      wdata,
  input logic [BLOCK_BITS+PAGE_BITS+7:0] mem_addr,
  input logic [BLOCK_BITS-1:0]           blk_q,
  input logic [PAGE_BITS-1:0]            pg_q,
  input logic                            wr_blk,
  input logic                            wr_pg
);

  logic [7:0] wdata_z;
  assign wdata_z = wdata;

  // R2
  a_r2_block_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_area && wr_en && addr[7] && addr[0]) |=> (blk_q == $past(wdata_z[BLOCK_BITS-1:0])));

  // R3
  a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_area && wr_en && addr[7] && !addr[0]) |=> (pg_q == $past(wdata_z[PAGE_BITS-1:0])));

  // R4
  a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_blk, wr_pg}));

  // R5
  a_r5_low_half_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_area && wr_en && !addr[7]) |=> ($stable(blk_q) && $stable(pg_q)));

  // R6
  a_r6_no_strobe_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_area && wr_en)) |=> ($stable(blk_q) && $stable(pg_q)));

  // R8
  a_r8_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[7:0] == addr) && (mem_addr[PAGE_BITS+7:8] == pg_q));

endmodule

bind mbw_window mbw_window_chk #(.BLOCK_BITS(BLOCK_BITS), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_area (reg_area),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .mem_addr (mem_addr),
  .blk_q    (blk_q),
  .pg_q     (pg_q),
  .wr_blk   (wr_blk),
  .wr_pg    (wr_pg)
);

// File: tb/test_mbw_window.sv
`timescale 1ns/1ps
module test_mbw_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_area = 1'b0;
  logic        win_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [18:0] mem_addr;
  logic [21:0] mem_addr_w;
  logic        win_cs;
  logic        win_cs_w;

  int n_chk = 0;
  int n_bad = 0;

  int unsigned e_blk = 0;
  int unsigned e_blkw = 0;
  int unsigned e_pg = 0;
  string       last_tag = "R1";

  always #4 clk = ~clk;

  mbw_window i_mbw_window (
    .clk (clk), .rst_n (rst_n), .reg_area (reg_area), .win_sel (win_sel),
    .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .mem_addr (mem_addr), .win_cs (win_cs)
  );

  mbw_window #(.BLOCK_BITS(8)) i_mbw_window_wide (
    .clk (clk), .rst_n (rst_n), .reg_area (reg_area), .win_sel (win_sel),
    .wr_en (wr_en), .addr (addr), .wdata (wdata),
    .mem_addr (mem_addr_w), .win_cs (win_cs_w)
  );

  function automatic int unsigned exp_xaddr(int unsigned b, int unsigned p, int unsigned a);
    return b * 16384 + p * 256 + a;
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, 32'(mem_addr), exp_xaddr(e_blk, e_pg, addr));
    check((tag == "R7") ? "R10" : tag, 32'(mem_addr_w), exp_xaddr(e_blkw, e_pg, addr));
    check("R9", 32'(win_cs), 32'(win_sel));
    check("R9", 32'(win_cs_w), 32'(win_sel));
  endtask

  // Drive one bus cycle at the falling edge, check state left by earlier edges,
  // then update the model for what the coming rising edge does.
  task automatic apply(logic ra, logic ws, logic we, logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    reg_area = ra; win_sel = ws; wr_en = we; addr = a; wdata = d;
    #1;
    check_all(last_tag);
    if (ra && we && a[7]) begin
      if (a[0]) begin
        e_blk  = d % 32;
        e_blkw = d;
      end else begin
        e_pg = d % 64;
      end
    end
    last_tag = tag;
  endtask

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    // R1: writes attempted during reset are not taken
    @(negedge clk);
    reg_area = 1'b1; wr_en = 1'b1; addr = 8'hFF; wdata = 8'h1F;
    repeat (3) @(negedge clk);
    reg_area = 1'b0; wr_en = 1'b0; addr = 8'h5A;
    rst_n = 1'b1;
    #1;
    check_all("R1");

    // R2/R7/R10: block write with all data bits set
    apply(1, 0, 1, 8'hFF, 8'hFF, "R7");
    // R3/R4: page write through a mirror offset
    apply(1, 0, 1, 8'h80, 8'hFF, "R3");
    // R5: lower half ignored
    apply(1, 0, 1, 8'h7F, 8'h03, "R5");
    apply(1, 0, 1, 8'h7E, 8'h05, "R5");
    // R6: window write, and register strobe without write
    apply(0, 1, 1, 8'hFF, 8'h11, "R6");
    apply(1, 0, 0, 8'hFE, 8'h22, "R6");
    // R4: mirror offsets inside upper half
    apply(1, 0, 1, 8'hAB, 8'h15, "R4");
    apply(1, 0, 1, 8'hC4, 8'h2A, "R4");
    // R8/R9: offset sweep with window strobe
    for (int i = 0; i < 8; i++) apply(0, 1, 0, 8'(i * 37), 8'h00, "R8");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned k;
      logic [7:0]  a;
      logic [7:0]  d;
      string       t;
      k = $urandom % 6;
      a = 8'($urandom);
      d = 8'($urandom);
      case (k)
        0: begin a[7] = 1'b1; a[0] = 1'b1; t = "R2"; apply(1, 0, 1, a, d, t); end
        1: begin a[7] = 1'b1; a[0] = 1'b0; t = "R3"; apply(1, 0, 1, a, d, t); end
        2: begin a[7] = 1'b0;              t = "R5"; apply(1, 0, 1, a, d, t); end
        3: begin                           t = "R6"; apply(0, 1'($urandom), 1, a, d, t); end
        4: begin                           t = "R6"; apply(1, 0, 0, a, d, t); end
        default: begin                     t = "R8"; apply(0, 1'($urandom), 0, a, d, t); end
      endcase
    end
    apply(0, 0, 0, 8'h00, 8'h00, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule